// File: doc/BRIEF.md
# Register Value Shadow Checker

This block runs beside a processor register file and protects it against transient upsets without duplicating the whole file. It keeps a small, fully associative shadow of recently written register values. Each shadow entry holds a register tag, a valid bit, the value and an 8-bit CRC of that value. Every write updates the shadow. Every read that hits a valid entry is compared against the data the register file returned.

When the two copies disagree, the block holds the pipeline for one cycle. During that cycle it recomputes the CRC of the shadowed value to decide which copy is damaged. If the shadow copy is intact, it supplies the shadow value as the corrected read data and pulses the error flag to report a register-file fault. If the shadow copy is itself damaged, it supplies the register-file value, drops the entry and reports no error. Reads that miss the shadow pass through unchecked.

Top module: `rvc_guard`

## Requirements
- R1: After reset, `stall_o` and `error_o` are low and every shadow entry is invalid, so a read of any register passes through with no stall.
- R2: Outside the stall cycle, `rd_data_o` equals `rf_rd_data_i` in the same cycle. A read that misses the shadow never stalls.
- R3: A read whose register-file data equals the shadowed value does not stall and raises no error.
- R4: A read that hits, with `rd_en_i` high and data that differs from the shadowed value, drives `stall_o` high in the next cycle for exactly one cycle.
- R5: If the shadowed value passes its CRC check, `rd_data_o` carries the shadowed value during the stall cycle. `error_o` is then high for exactly one cycle, the cycle after the stall.
- R6: If the shadowed value fails its CRC check, `rd_data_o` carries the register-file data that was captured with the read, during the stall cycle. `error_o` stays low and the entry is invalidated, so the next read of that register is not checked. The CRC is CRC-8 with polynomial 0x07 and a zero initial value, taken MSB first over the data word. Any single-bit corruption of a stored value therefore fails the check.
- R7: A write to a register that is already shadowed updates that entry in place and does not allocate a new entry.
- R8: A write to a register that is not shadowed allocates entries round-robin, starting at entry 0 after reset. The pointer advances only on such allocations, and a full shadow overwrites the entry under the pointer.
- R9: With `rd_en_i` low, no check is started whatever the read inputs are.
- R10: Write and read inputs presented during the stall cycle are ignored. The write does not enter the shadow and the read is not checked.
- R11: A read whose address equals the address written in the same cycle is not checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW (5) | Destination register |
| wr_data_i | input | DW (32) | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | AW (5) | Source register |
| rf_rd_data_i | input | DW (32) | Data returned by the register file |
| stall_o | output | 1 | Pipeline hold during the check cycle |
| error_o | output | 1 | One-cycle pulse on a register-file fault |
| rd_data_o | output | DW (32) | Corrected read data |

## Verification
The bench flips each of the 32 data bits in turn on the register-file side. A checker that skipped the comparison, or stalled for more or fewer than one cycle, would miss or stretch the hold. It also flips each bit of a shadow entry's stored value through a forced upset. A design whose CRC failed to catch some bit position would then forward the damaged shadow value and raise a false error. A design that forgot to invalidate the entry would keep stalling on later reads. The bench also fills the shadow past capacity and rewrites present registers, which exposes wrong eviction order and duplicate tags. Finally, it drives traffic during the stall cycle and same-address write/read pairs, which a design would wrongly absorb or check.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
  localparam int unsigned CRC_W    = 8;
  localparam logic [7:0]  CRC_POLY = 8'h07;
endpackage

// File: rtl/rvc_crc8.sv
module rvc_crc8 #(
  parameter int unsigned DW   = 32,
  parameter int unsigned CW   = rvc_pkg::CRC_W,
  parameter logic [CW-1:0] POLY = rvc_pkg::CRC_POLY
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] crc_o
);
  always_comb begin
    logic [CW-1:0] c;
    logic          fb;
    c = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      fb = c[CW-1] ^ data_i[i];
      c  = {c[CW-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    crc_o = c;
  end
endmodule

// File: rtl/rvc_entry.sv
module rvc_entry #(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          clr_i,
  input  logic [AW-1:0] tag_i,
  input  logic [DW-1:0] val_i,
  input  logic [CW-1:0] crc_i,
  output logic          vld_o,
  output logic [AW-1:0] tag_o,
  output logic [DW-1:0] val_o,
  output logic [CW-1:0] crc_o
);
  logic          vld_q;
  logic [AW-1:0] tag_q;
  logic [DW-1:0] val_q;
  logic [CW-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      tag_q <= '0;
      val_q <= '0;
      crc_q <= '0;
    end else if (load_i) begin
      vld_q <= 1'b1;
      tag_q <= tag_i;
      val_q <= val_i;
      crc_q <= crc_i;
    end else if (clr_i) begin
      vld_q <= 1'b0;
    end
  end

  assign vld_o = vld_q;
  assign tag_o = tag_q;
  assign val_o = val_q;
  assign crc_o = crc_q;

  p_clr_drops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !load_i) |=> !vld_o);
endmodule

// File: rtl/rvc_store.sv
module rvc_store #(
  parameter int unsigned N  = 8,
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [CW-1:0] wr_crc_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          rd_hit_o,
  output logic [IW-1:0] rd_idx_o,
  output logic [DW-1:0] rd_val_o,
  output logic [CW-1:0] rd_crc_o,
  input  logic          clr_i,
  input  logic [IW-1:0] clr_idx_i
);
  logic [N-1:0]          vld, wr_hv, rd_hv, load, clr;
  logic [N-1:0][AW-1:0]  tag;
  logic [N-1:0][DW-1:0]  val;
  logic [N-1:0][CW-1:0]  crc;
  logic                  wr_hit;
  logic [IW-1:0]         rr_q;

  assign wr_hit = |wr_hv;

  for (genvar i = 0; i < N; i++) begin : g_ent
    assign wr_hv[i] = vld[i] && (tag[i] == wr_addr_i);
    assign rd_hv[i] = vld[i] && (tag[i] == rd_addr_i);
    assign load[i]  = wr_en_i && (wr_hit ? wr_hv[i] : (rr_q == IW'(i)));
    assign clr[i]   = clr_i && (clr_idx_i == IW'(i));
    rvc_entry #(.AW(AW), .DW(DW), .CW(CW)) u_ent (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(load[i]),
      .clr_i (clr[i]),
      .tag_i (wr_addr_i),
      .val_i (wr_data_i),
      .crc_i (wr_crc_i),
      .vld_o (vld[i]),
      .tag_o (tag[i]),
      .val_o (val[i]),
      .crc_o (crc[i])
    );
  end

  always_comb begin
    rd_idx_o = '0;
    rd_val_o = '0;
    rd_crc_o = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_hv[i]) begin
        rd_idx_o = IW'(i);
        rd_val_o = val[i];
        rd_crc_o = crc[i];
      end
    end
  end
  assign rd_hit_o = |rd_hv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (wr_en_i && !wr_hit) rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
  end

  p_tag_unique_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_hv));
  p_wr_tag_unique_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_hv));
endmodule

// File: rtl/rvc_guard.sv
module rvc_guard #(
  parameter int unsigned N  = 8,
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32,
  localparam int unsigned CW = rvc_pkg::CRC_W,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [DW-1:0] rf_rd_data_i,
  output logic          stall_o,
  output logic          error_o,
  output logic [DW-1:0] rd_data_o
);
  logic          chk_q, err_q;
  logic [IW-1:0] chk_idx_q;
  logic [DW-1:0] chk_val_q, chk_rf_q;
  logic [CW-1:0] chk_crc_q;
  logic [CW-1:0] wr_crc, chk_crc_calc;
  logic          hit;
  logic [IW-1:0] hit_idx;
  logic [DW-1:0] hit_val;
  logic [CW-1:0] hit_crc;
  logic          wr_go, same_wr, start, crc_ok;

  assign wr_go   = wr_en_i && !chk_q;
  assign same_wr = wr_en_i && (wr_addr_i == rd_addr_i);
  assign start   = rd_en_i && !chk_q && hit && !same_wr && (hit_val != rf_rd_data_i);
  assign crc_ok  = (chk_crc_calc == chk_crc_q);

  rvc_crc8 #(.DW(DW), .CW(CW)) u_crc_wr  (.data_i(wr_data_i), .crc_o(wr_crc));
  rvc_crc8 #(.DW(DW), .CW(CW)) u_crc_chk (.data_i(chk_val_q), .crc_o(chk_crc_calc));

  rvc_store #(.N(N), .AW(AW), .DW(DW), .CW(CW)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_go),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .wr_crc_i (wr_crc),
    .rd_addr_i(rd_addr_i),
    .rd_hit_o (hit),
    .rd_idx_o (hit_idx),
    .rd_val_o (hit_val),
    .rd_crc_o (hit_crc),
    .clr_i    (chk_q && !crc_ok),
    .clr_idx_i(chk_idx_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_q     <= 1'b0;
      err_q     <= 1'b0;
      chk_idx_q <= '0;
      chk_val_q <= '0;
      chk_rf_q  <= '0;
      chk_crc_q <= '0;
    end else begin
      chk_q <= start;
      err_q <= chk_q && crc_ok;
      if (start) begin
        chk_idx_q <= hit_idx;
        chk_val_q <= hit_val;
        chk_crc_q <= hit_crc;
        chk_rf_q  <= rf_rd_data_i;
      end
    end
  end

  // during the check cycle, forward whichever copy survived
  assign rd_data_o = !chk_q ? rf_rd_data_i : (crc_ok ? chk_val_q : chk_rf_q);
  assign stall_o   = chk_q;
  assign error_o   = err_q;

  p_stall_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o);
  p_stall_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> $past(rd_en_i));
  p_err_after_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> $past(stall_o));
  p_no_chk_same_wr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && same_wr && !stall_o) |=> !stall_o);
  p_err_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> !error_o);
endmodule

// File: tb/sim_rvc_guard.sv
`timescale 1ns/1ps
module sim_rvc_guard;
  localparam int N = 8, AW = 5, DW = 32;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rf_data = '0;
  logic          stall, error;
  logic [DW-1:0] rd_data;

  always #2 clk = ~clk;

  rvc_guard #(.N(N), .AW(AW), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rf_rd_data_i(rf_data), .stall_o(stall), .error_o(error), .rd_data_o(rd_data));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic          m_vld [N];
  logic [AW-1:0] m_tag [N];
  logic [DW-1:0] m_val [N];
  logic          m_bad [N];
  int            m_ptr;
  logic [DW-1:0] fval;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_find(input logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == a) return i;
    return -1;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int k;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
    k = m_find(a);
    if (k >= 0) begin
      m_val[k] = d; m_bad[k] = 1'b0;
    end else begin
      m_vld[m_ptr] = 1'b1; m_tag[m_ptr] = a; m_val[m_ptr] = d; m_bad[m_ptr] = 1'b0;
      m_ptr = (m_ptr + 1) % N;
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] rf, input string req);
    int  k;
    bit  exp_stall, exp_err;
    logic [DW-1:0] exp_d;
    k = m_find(a);
    exp_stall = (k >= 0) && (m_val[k] != rf);
    rd_en = 1'b1; rd_addr = a; rf_data = rf;
    #1 chk(rd_data == rf, {req, " R2 pass-through"}, rd_data, rf);
    tick();
    rd_en = 1'b0; rf_data = '0;
    #0 chk(stall == exp_stall, {req, " stall"}, DW'(stall), DW'(exp_stall));
    if (exp_stall) begin
      exp_err = !m_bad[k];
      exp_d   = m_bad[k] ? rf : m_val[k];
      #1 chk(rd_data == exp_d, {req, " corrected data"}, rd_data, exp_d);
      if (m_bad[k]) m_vld[k] = 1'b0;
      tick();
      chk(stall == 1'b0, {req, " R4 stall one cycle"}, DW'(stall), 0);
      chk(error == exp_err, {req, " error pulse"}, DW'(error), DW'(exp_err));
      tick();
      chk(error == 1'b0, {req, " R5 error one cycle"}, DW'(error), 0);
    end else begin
      chk(error == 1'b0, {req, " no error"}, DW'(error), 0);
    end
  endtask

  task automatic corrupt(input int slot, input logic [DW-1:0] mask);
    fval = m_val[slot] ^ mask;
    case (slot)
      0: begin force u0.u_store.g_ent[0].u_ent.val_q = fval; #1 release u0.u_store.g_ent[0].u_ent.val_q; end
      1: begin force u0.u_store.g_ent[1].u_ent.val_q = fval; #1 release u0.u_store.g_ent[1].u_ent.val_q; end
      2: begin force u0.u_store.g_ent[2].u_ent.val_q = fval; #1 release u0.u_store.g_ent[2].u_ent.val_q; end
      3: begin force u0.u_store.g_ent[3].u_ent.val_q = fval; #1 release u0.u_store.g_ent[3].u_ent.val_q; end
      4: begin force u0.u_store.g_ent[4].u_ent.val_q = fval; #1 release u0.u_store.g_ent[4].u_ent.val_q; end
      5: begin force u0.u_store.g_ent[5].u_ent.val_q = fval; #1 release u0.u_store.g_ent[5].u_ent.val_q; end
      6: begin force u0.u_store.g_ent[6].u_ent.val_q = fval; #1 release u0.u_store.g_ent[6].u_ent.val_q; end
      default: begin force u0.u_store.g_ent[7].u_ent.val_q = fval; #1 release u0.u_store.g_ent[7].u_ent.val_q; end
    endcase
    m_val[slot] = fval;
    m_bad[slot] = 1'b1;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_tag[i] = '0; m_val[i] = '0; m_bad[i] = 0; end
    m_ptr = 0;
    #5 rst_n = 1'b1;
    tick();
    // R1: reset state
    chk(stall == 1'b0, "R1 stall low", DW'(stall), 0);
    chk(error == 1'b0, "R1 error low", DW'(error), 0);
    do_read(5'd1, 32'hDEAD_BEEF, "R1 empty");
    // R2: miss
    do_read(5'd9, 32'h1234_5678, "R2 miss");
    // R3: fill and read matching
    for (int r = 1; r <= 8; r++) do_write(AW'(r), 32'hA000_0000 + 32'(r * 17));
    for (int r = 1; r <= 8; r++) do_read(AW'(r), 32'hA000_0000 + 32'(r * 17), "R3 match");
    // R4 R5: every register-file bit flip
    for (int b = 0; b < DW; b++) begin
      do_write(5'd2, 32'h5A5A_0000 ^ 32'(b));
      do_read(5'd2, (32'h5A5A_0000 ^ 32'(b)) ^ (32'd1 << b), "R5 rf fault");
    end
    // R6: every shadow bit flip
    for (int b = 0; b < DW; b++) begin
      int k;
      do_write(5'd3, 32'h0F0F_3C3C + 32'(b));
      k = m_find(5'd3);
      corrupt(k, 32'd1 << b);
      do_read(5'd3, 32'h0F0F_3C3C + 32'(b), "R6 shadow fault");
      chk(m_find(5'd3) < 0, "R6 model invalid", 0, 0);
      do_read(5'd3, 32'hFFFF_0000, "R6 after invalidate");
    end
    // R7: in-place update
    do_write(5'd4, 32'h1111_1111);
    do_write(5'd4, 32'h2222_2222);
    do_read(5'd4, 32'h2222_2222, "R7 new value");
    do_read(5'd4, 32'h1111_1111, "R7 old value");
    // R8: fill past capacity, round-robin eviction
    for (int r = 10; r <= 18; r++) do_write(AW'(r), 32'hC000_0000 + 32'(r));
    for (int r = 10; r <= 18; r++) do_read(AW'(r), 32'h0BAD_0000 + 32'(r), "R8 eviction");
    do_write(5'd10, 32'h7777_0000);
    do_write(5'd12, 32'h7777_0012);
    do_read(5'd11, 32'h0, "R8 rr pointer");
    // R9: rd_en low
    rd_en = 1'b0; rd_addr = 5'd12; rf_data = 32'h0;
    tick();
    chk(stall == 1'b0, "R9 no check when rd_en low", DW'(stall), 0);
    // R10: traffic during stall ignored
    rd_en = 1'b1; rd_addr = 5'd12; rf_data = 32'h0;
    tick();
    chk(stall == 1'b1, "R10 stall entered", DW'(stall), 1);
    wr_en = 1'b1; wr_addr = 5'd20; wr_data = 32'hABCD_0020;
    rd_en = 1'b1; rd_addr = 5'd12; rf_data = 32'h0;
    tick();
    wr_en = 1'b0; rd_en = 1'b0;
    chk(stall == 1'b0, "R10 read in stall not checked", DW'(stall), 0);
    chk(error == 1'b1, "R10 error from first read", DW'(error), 1);
    tick();
    do_read(5'd20, 32'h0000_0001, "R10 write in stall dropped");
    // R11: same-cycle write and read of one register
    wr_en = 1'b1; wr_addr = 5'd12; wr_data = 32'h3333_0012;
    rd_en = 1'b1; rd_addr = 5'd12; rf_data = 32'h9999_9999;
    tick();
    wr_en = 1'b0; rd_en = 1'b0;
    chk(stall == 1'b0, "R11 same-address read unchecked", DW'(stall), 0);
    m_val[m_find(5'd12)] = 32'h3333_0012;
    do_read(5'd12, 32'h3333_0012, "R11 write took effect");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule